// File: doc/BRIEF.md
# Capture/Compare Timer with Event Counting

This block is a 16-bit up-counter that runs off the system clock. It has two capture/compare registers, called slot A and slot B, two filtered external inputs (pin 0 and pin 1), one output pin and two one-clock interrupt pulses. Software sets the mode, the edge selection, the capture routing and the compare values through a small synchronous register port, then starts the counter by setting the run bit.

There are four counting modes: free-running, cleared on a slot-A match, cleared on a valid pin-0 edge, and event counting on pin-0 edges. The output pin toggles on every slot-B match. A one-shot variant instead drives a single pulse from the slot-B match to the slot-A match after a software trigger. Slot A can also capture the count on a pin edge. A sticky overflow flag records a wrap from 0xFFFF to 0.

A small state machine sequences the counter. It has the states IDLE, SYNC, EV_WAIT1, EV_WAIT2 and RUN. A run-bit set moves IDLE to SYNC, where the counter is zeroed. SYNC goes to EV_WAIT1 in event mode and to RUN otherwise. EV_WAIT1 goes to EV_WAIT2 on a valid pin-0 edge, and EV_WAIT2 goes to RUN on the next one. Clearing the run bit returns any state to IDLE.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, the output pin, both interrupts and the overflow flag are 0, and all four readable registers read 0. Addresses: 0 control, 1 slot A, 2 slot B, 3 counter (read only).
- R2: Control register fields: [1:0] mode (0 free-running, 1 clear on slot-A match, 2 clear on pin-0 edge, 3 event count), [2] run, [4:3] pin-0 edge select, [6:5] pin-1 edge select, [7] slot-A capture enable, [8] slot-A capture source (0 pin 1, 1 pin 0), [9] one-shot enable, [10] one-shot trigger (write only). In free-running mode, a count equal to slot B gives one irq_cc1 pulse and toggles out_pin.
- R3: In mode 1 with slot A = C, the count runs 0..C and wraps, giving an irq_cc0 pulse every C+1 clocks. The overflow flag is never set in this mode.
- R4: In mode 2, a valid pin-0 edge clears the counter to 0.
- R5: In mode 3, the first two valid pin-0 edges after start only arm the counter. Each later valid edge adds one.
- R6: A pin level is accepted only after 3 consecutive identical samples, so a pulse of 2 clocks has no effect.
- R7: Edge select encoding: 0 none, 1 rising, 2 falling, 3 both. An edge that is not selected causes no capture and no interrupt.
- R8: With capture enabled and source 0, a selected pin-1 edge loads the counter into slot A and pulses irq_cc0.
- R9: With source 1, a selected pin-0 edge captures into slot A, except when pin 0 selects both edges, in which case nothing is captured. A selected pin-1 edge pulses irq_cc0 without loading slot A.
- R10: With one-shot enabled in mode 0 or 2, a trigger restarts the count at 0. out_pin then goes high at the slot-B match and low at the slot-A match, once. Without a trigger it stays low. In modes 1 and 3 the trigger is ignored.
- R11: A slot-B write landing on the clock of a slot-B match uses the old value, so the match gives exactly one toggle and one irq_cc1.
- R12: The overflow flag sets when the count wraps from 0xFFFF to 0 and clears on the next start.
- R13: Start is synchronized. The counter holds 0 for two clocks after the run write and first advances on the second clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 2 | Write address |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 16 | Read data (combinational) |
| in0 | input | 1 | External input 0 |
| in1 | input | 1 | External input 1 |
| out_pin | output | 1 | Toggle / one-shot output |
| irq_cc0 | output | 1 | Slot-A match or capture pulse |
| irq_cc1 | output | 1 | Slot-B match pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The counter is driven under each of the four modes. Timed interrupt arrivals separate a free-running count from a count cleared on slot A. Reading the counter after pin pulses separates pin-0 clearing from event counting, and shows whether the two arming edges were consumed. Pin pulses of 2 and 3 clocks fall on either side of the filter threshold. Rising-only, both-edge and unselected edges on each pin, under each capture source, separate a real capture from the suppressed capture and from the interrupt-only path. A slot-B write timed onto the match clock, and one-shot triggers in allowed and forbidden modes, complete the corner cases.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_EVW1,
        ST_EVW2,
        ST_RUN
    } tmr_state_e;

    typedef enum logic [1:0] {
        MD_FREE    = 2'd0,
        MD_CLR_CMP = 2'd1,
        MD_CLR_IN  = 2'd2,
        MD_EVENT   = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        logic       oneshot;
        logic       cap_src;
        logic       cap_en;
        logic [1:0] in1_sel;
        logic [1:0] in0_sel;
        logic       run;
        tmr_mode_e  mode;
    } ctrl_t;

    function automatic logic edge_hit(logic [1:0] sel, logic rise, logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

endpackage

// File: rtl/capcmp_filter.sv
module capcmp_filter #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [DEPTH-1:0] samp_q;
    logic             lvl_q;
    logic             upd;

    assign upd  = ((&samp_q) || !(|samp_q)) && (samp_q[0] != lvl_q);
    assign rise = upd && samp_q[0];
    assign fall = upd && !samp_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            lvl_q  <= 1'b0;
        end else begin
            samp_q <= {samp_q[DEPTH-2:0], din};
            if (upd) lvl_q <= samp_q[0];
        end
    end
endmodule

// File: rtl/capcmp_fsm.sv
module capcmp_fsm
    import capcmp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       stop,
    input  logic       is_event,
    input  logic       ev_edge,
    output tmr_state_e state,
    output logic       counting
);
    tmr_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_SYNC;
            ST_SYNC: st_d = is_event ? ST_EVW1 : ST_RUN;
            ST_EVW1: if (ev_edge) st_d = ST_EVW2;
            ST_EVW2: if (ev_edge) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
        if (stop) st_d = ST_IDLE;
    end

    always_comb begin
        state    = st_q;
        counting = (st_q == ST_RUN);
    end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int W    = 16,
    parameter int FILT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic [1:0]   bus_waddr,
    input  logic [W-1:0] bus_wdata,
    input  logic [1:0]   bus_raddr,
    output logic [W-1:0] bus_rdata,
    input  logic         in0,
    input  logic         in1,
    output logic         out_pin,
    output logic         irq_cc0,
    output logic         irq_cc1,
    output logic         ovf_flag
);
    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int RUN_BIT  = 2;
    localparam int TRIG_BIT = CTRL_W;
    localparam int NPIN     = 2;

    ctrl_t      ctrl_q;
    logic [W-1:0] cc0_q, cc1_q, cnt_q;
    tmr_state_e st_q;
    logic       counting;
    logic       armed_q;

    logic [NPIN-1:0] pins, p_rise, p_fall;
    assign pins = {in1, in0};

    for (genvar i = 0; i < NPIN; i++) begin : g_filt
        capcmp_filter #(.DEPTH(FILT)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pins[i]),
            .rise (p_rise[i]),
            .fall (p_fall[i])
        );
    end

    logic wr_ctrl, start_cmd, stop_cmd, trig_cmd;
    logic in0_hit, in1_hit, clr_in, tick, m0, m1, cap_evt, irq0_d, osh_mode;

    assign wr_ctrl   = bus_we && (bus_waddr == 2'd0);
    assign start_cmd = wr_ctrl && bus_wdata[RUN_BIT] && !ctrl_q.run;
    assign stop_cmd  = wr_ctrl && !bus_wdata[RUN_BIT] && ctrl_q.run;
    assign osh_mode  = (ctrl_q.mode == MD_FREE) || (ctrl_q.mode == MD_CLR_IN);
    assign trig_cmd  = wr_ctrl && bus_wdata[TRIG_BIT] && bus_wdata[RUN_BIT]
                       && ctrl_q.oneshot && counting && osh_mode;

    assign in0_hit = edge_hit(ctrl_q.in0_sel, p_rise[0], p_fall[0]);
    assign in1_hit = edge_hit(ctrl_q.in1_sel, p_rise[1], p_fall[1]);
    assign clr_in  = counting && (ctrl_q.mode == MD_CLR_IN) && in0_hit;
    assign tick    = counting && !trig_cmd && !clr_in
                     && ((ctrl_q.mode == MD_EVENT) ? in0_hit : 1'b1);
    assign m0      = tick && !ctrl_q.cap_en && (cnt_q == cc0_q);
    assign m1      = tick && (cnt_q == cc1_q);
    assign cap_evt = counting && ctrl_q.cap_en &&
                     (ctrl_q.cap_src ? (in0_hit && (ctrl_q.in0_sel != 2'b11)) : in1_hit);
    assign irq0_d  = m0 || cap_evt || (counting && ctrl_q.cap_src && in1_hit);

    capcmp_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_cmd),
        .stop    (stop_cmd),
        .is_event(ctrl_q.mode == MD_EVENT),
        .ev_edge (in0_hit),
        .state   (st_q),
        .counting(counting)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cc0_q  <= '0;
            cc1_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (cap_evt) cc0_q <= cnt_q;
            else if (bus_we && bus_waddr == 2'd1) cc0_q <= bus_wdata;
            if (bus_we && bus_waddr == 2'd2) cc1_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (start_cmd || trig_cmd || clr_in)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= ((ctrl_q.mode == MD_CLR_CMP) && m0) ? '0 : cnt_q + 1'b1;
            if (start_cmd)
                ovf_flag <= 1'b0;
            else if (tick && (&cnt_q) && !((ctrl_q.mode == MD_CLR_CMP) && m0))
                ovf_flag <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_pin <= 1'b0;
            armed_q <= 1'b0;
            irq_cc0 <= 1'b0;
            irq_cc1 <= 1'b0;
        end else begin
            irq_cc0 <= irq0_d;
            irq_cc1 <= m1;
            if (start_cmd) begin
                out_pin <= 1'b0;
                armed_q <= 1'b0;
            end else if (trig_cmd) begin
                out_pin <= 1'b0;
                armed_q <= 1'b1;
            end else if (ctrl_q.oneshot) begin
                if (armed_q && m0) begin
                    out_pin <= 1'b0;
                    armed_q <= 1'b0;
                end else if (armed_q && m1) begin
                    out_pin <= 1'b1;
                end
            end else if (m1) begin
                out_pin <= !out_pin;
            end
        end
    end

    always_comb begin
        unique case (bus_raddr)
            2'd0: bus_rdata = W'(ctrl_q);
            2'd1: bus_rdata = cc0_q;
            2'd2: bus_rdata = cc1_q;
            default: bus_rdata = cnt_q;
        endcase
    end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk
    import capcmp_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input tmr_state_e   state,
    input logic [W-1:0] cnt,
    input logic         start,
    input logic         trig,
    input logic         out_pin,
    input logic         irq_cc0,
    input logic         irq_cc1,
    input logic         ovf_flag
);
    assert_out_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_pin != $past(out_pin)) |-> (irq_cc0 || irq_cc1 || $past(start) || $past(trig)));

    assert_irq1_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cc1 |=> !irq_cc1);

    assert_evwait_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_EVW1) || (state == ST_EVW2)) |-> (cnt == '0));

    assert_ovf_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cnt) == {W{1'b1}}));

    assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !start) |=> $stable(cnt));
endmodule

bind capcmp_timer capcmp_timer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (st_q),
    .cnt     (cnt_q),
    .start   (start_cmd),
    .trig    (trig_cmd),
    .out_pin (out_pin),
    .irq_cc0 (irq_cc0),
    .irq_cc1 (irq_cc1),
    .ovf_flag(ovf_flag)
);

// File: tb/capcmp_timer_tb_top.sv
module capcmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_raddr = '0;
    logic [15:0] bus_rdata;
    logic        in0 = 1'b0, in1 = 1'b0;
    logic        out_pin, irq_cc0, irq_cc1, ovf_flag;

    always #4 clk = ~clk;

    capcmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .in0(in0), .in1(in1), .out_pin(out_pin), .irq_cc0(irq_cc0),
        .irq_cc1(irq_cc1), .ovf_flag(ovf_flag)
    );

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    int k = 0;
    bit sb_on = 0;
    bit done = 0;
    logic [15:0] v;

    typedef struct { int src; int lo; int hi; } exp_t;
    exp_t sbq[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // monitor: pops expected interrupt items as pulses appear
    always @(negedge clk) begin
        if (sb_on) begin
            for (int s = 0; s < 2; s++) begin
                logic hit;
                hit = (s == 1) ? irq_cc1 : irq_cc0;
                if (hit) begin
                    n_chk++;
                    if (sbq.size() == 0) begin
                        n_bad++;
                        $display("FAIL R2/R3/R7/R8/R9/R11 unexpected irq%0d actual=cycle %0d expected=none", s, cyc);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        if (e.src != s || cyc < e.lo || cyc > e.hi) begin
                            n_bad++;
                            $display("FAIL R2/R3/R8/R9/R11 irq actual=src%0d@%0d expected=src%0d@%0d..%0d",
                                     s, cyc, e.src, e.lo, e.hi);
                        end
                    end
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
        k = cyc;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [15:0] cw(int mode, bit run, int s0, int s1,
                                       bit cen, bit csrc, bit osh, bit trg);
        return 16'((mode & 3) | (int'(run) << 2) | ((s0 & 3) << 3) | ((s1 & 3) << 5) |
                   (int'(cen) << 7) | (int'(csrc) << 8) | (int'(osh) << 9) | (int'(trg) << 10));
    endfunction

    task automatic push(int src, int at);
        sbq.push_back(exp_t'{src, at - 1, at + 1});
    endtask

    task automatic pin_pulse(bit which, int width);
        @(negedge clk);
        if (which) in1 = 1'b1; else in0 = 1'b1;
        step(width);
        if (which) in1 = 1'b0; else in0 = 1'b0;
        step(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);
        // R1 reset state
        chk("R1 out_pin", out_pin, 0);
        chk("R1 irq", {irq_cc0, irq_cc1}, 0);
        chk("R1 ovf", ovf_flag, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 register", v, 0);
        end

        // R13 / R2 free-running, first match inside the start window
        wr(1, 1000); wr(2, 20);
        sb_on = 1;
        wr(0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        push(1, k + 22);
        step(5); rd(3, v);
        chk("R13 count after start", v, 3);
        step(25);
        chk("R2 out toggled", out_pin, 1);
        chk("R2 queue drained", sbq.size(), 0);
        wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0));

        // R3 clear on slot-A match
        wr(1, 9); wr(2, 500);
        wr(0, cw(1, 1, 0, 0, 0, 0, 0, 0));
        push(0, k + 11); push(0, k + 21); push(0, k + 31);
        step(34);
        wr(0, cw(1, 0, 0, 0, 0, 0, 0, 0));
        chk("R3 periodic irq", sbq.size(), 0);
        chk("R3 no overflow", ovf_flag, 0);
        rd(3, v);
        chk("R3 count bounded", v <= 9, 1);

        // R11 slot-B write on the match clock
        wr(2, 30); wr(1, 1000);
        wr(0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        push(1, k + 32);
        step(31);
        wr(2, 200);
        step(10);
        chk("R11 single toggle", out_pin, 1);
        chk("R11 single irq", sbq.size(), 0);
        rd(2, v);
        chk("R11 new value kept", v, 200);
        wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0));

        // R8 capture from pin 1
        wr(1, 0);
        wr(0, cw(0, 1, 0, 1, 1, 0, 0, 0));
        step(49);
        in1 = 1'b1;
        push(0, k + 52);
        step(10);
        rd(1, v);
        chk("R8 captured value", (v >= 49 && v <= 51), 1);
        chk("R8 irq", sbq.size(), 0);
        in1 = 1'b0;
        step(10);
        rd(1, v);
        chk("R7 falling edge not selected", (v >= 49 && v <= 51), 1);
        wr(0, cw(0, 1, 0, 0, 1, 0, 0, 0));
        pin_pulse(1, 5);
        rd(1, v);
        chk("R7 edge select none", (v >= 49 && v <= 51), 1);
        wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0));

        // R9 capture source pin 0
        wr(1, 16'h1234);
        wr(0, cw(0, 1, 3, 1, 1, 1, 0, 0));
        step(20);
        pin_pulse(0, 5);
        rd(1, v);
        chk("R9 both-edge suppresses capture", v, 16'h1234);
        @(negedge clk);
        push(0, cyc + 4);
        in1 = 1'b1; step(5); in1 = 1'b0; step(8);
        rd(1, v);
        chk("R9 pin-1 irq without load", v, 16'h1234);
        chk("R9 pin-1 irq seen", sbq.size(), 0);
        wr(0, cw(0, 1, 1, 1, 1, 1, 0, 0));
        @(negedge clk);
        push(0, cyc + 4);
        in0 = 1'b1; step(5); in0 = 1'b0; step(8);
        rd(1, v);
        chk("R9 rising pin-0 captures", (v > 20 && v != 16'h1234), 1);
        chk("R9 capture irq", sbq.size(), 0);
        wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0));
        sb_on = 0;

        // R5 / R6 event counting
        wr(2, 16'hF000); wr(1, 16'hF000);
        wr(0, cw(3, 1, 1, 0, 0, 0, 0, 0));
        step(4);
        pin_pulse(0, 4); pin_pulse(0, 4);
        rd(3, v);
        chk("R5 two arming edges", v, 0);
        pin_pulse(0, 4); pin_pulse(0, 4); pin_pulse(0, 4);
        rd(3, v);
        chk("R5 event count", v, 3);
        pin_pulse(0, 2);
        rd(3, v);
        chk("R6 short pulse rejected", v, 3);
        pin_pulse(0, 3);
        rd(3, v);
        chk("R6 three-sample pulse accepted", v, 4);
        wr(0, cw(3, 0, 1, 0, 0, 0, 0, 0));

        // R4 clear on pin-0 edge
        wr(0, cw(2, 1, 1, 0, 0, 0, 0, 0));
        step(60);
        @(negedge clk); in0 = 1'b1;
        step(5);
        rd(3, v);
        chk("R4 cleared by edge", v < 8, 1);
        in0 = 1'b0;
        wr(0, cw(2, 0, 1, 0, 0, 0, 0, 0));

        // R10 one-shot
        wr(1, 30); wr(2, 10);
        wr(0, cw(0, 1, 0, 0, 0, 0, 1, 0));
        step(40);
        chk("R10 no pulse without trigger", out_pin, 0);
        wr(0, cw(0, 1, 0, 0, 0, 0, 1, 1));
        step(18);
        chk("R10 pulse high", out_pin, 1);
        step(20);
        chk("R10 pulse ended", out_pin, 0);
        step(100);
        chk("R10 single pulse", out_pin, 0);
        wr(0, cw(0, 0, 0, 0, 0, 0, 1, 0));
        wr(1, 50);
        wr(0, cw(1, 1, 0, 0, 0, 0, 1, 0));
        step(30);
        wr(0, cw(1, 1, 0, 0, 0, 0, 1, 1));
        step(2);
        rd(3, v);
        chk("R10 trigger ignored in mode 1", v >= 25, 1);
        chk("R10 no output in mode 1", out_pin, 0);
        wr(0, cw(1, 0, 0, 0, 0, 0, 1, 0));

        // R12 overflow
        wr(1, 16'hFFF0); wr(2, 16'hFFF0);
        wr(0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        step(65530);
        chk("R12 not yet wrapped", ovf_flag, 0);
        step(15);
        chk("R12 wrap sets flag", ovf_flag, 1);
        wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0));
        wr(0, cw(0, 1, 0, 0, 0, 0, 0, 0));
        step(2);
        chk("R12 start clears flag", ovf_flag, 0);
        wr(0, cw(0, 0, 0, 0, 0, 0, 0, 0));

        done = 1;
        report();
        $finish;
    end
endmodule